// File: doc/BRIEF.md
# DDR3 Write-Leveling Strobe Delay Search

This block finds the strobe delay for one byte lane while a DDR3 controller performs write leveling. On a start pulse with leveling enabled it sets the strobe position to a programmed start offset, given in eighths of a clock period. For each candidate position it requests one strobe pulse and waits a programmable settle time. It then reads the single feedback bit that the DRAM returns, which is the clock level the DRAM sampled on the strobe edge. A level counts only once three consecutive identical samples agree. The search has to see a low level before it will take a high level as the leveling point. It moves the position up by one eighth per step until that low-to-high change appears, and it stops with an error if a programmed step limit runs out first.

With leveling disabled, a start pulse makes the block report a fixed write-data delay at once. The block also keeps a registered configuration flag for that mode. The flag is raised when the fixed delay plus the clock adjust would put the first strobe edge outside the allowed 0.75 to 1.25 clock window. It is also raised when a high-first write preamble is required but the fixed delay is one of the two settings that hold the preamble low for the whole cycle.

Top module: `wl_delay_search`

## Requirements
- R1: While reset is applied, and after it is released until the first start, `dqs_pulse_o`, `done_o`, `err_o` and `cfg_bad_o` are 0 and `dly_o` is 0.
- R2: Leveling disabled: a start pulse taken while idle or done makes `done_o` 1, `err_o` 0 and `dly_o` equal the fixed delay on the following cycle. No strobe pulse is requested.
- R3: Leveling enabled: a start pulse sets `dly_o` to the start field (eighths of a clock). Each step is one cycle with `dqs_pulse_o` high, followed by `settle_i`+1 wait cycles, followed by sampling cycles. A search that ends at step k produces exactly k+1 strobe pulses.
- R4: The feedback level is taken only in the sampling cycle that holds the third consecutive identical sample. A shorter run that is broken by the other level is ignored.
- R5: Until a low level has been taken, a high level taken is not a result: the position advances by one eighth and the search goes on.
- R6: Once a low has been taken, a high level taken ends the search. `done_o` becomes 1, `err_o` 0, `dly_o` holds start+k, and no further strobe pulses follow.
- R7: If the step count equals `max_step_i` (captured at start) when a level is taken that does not end the search, the search ends with `done_o` 1, `err_o` 1 and `dly_o` = start+`max_step_i`.
- R8: `cfg_bad_o` is registered one cycle after its inputs. With leveling disabled it is 1 when `fixed_dly_i`+`clk_adj_i` (eighths) is below 6 or above 10.
- R9: With leveling disabled and `hi_pre_req_i` 1, `cfg_bad_o` is also 1 when `fixed_dly_i` is 0 or 2 (0 or 1/4 clock).
- R10: With leveling enabled, `cfg_bad_o` is 0, and the fixed delay has no effect on the search or its result.
- R11: `done_o` and `dly_o` hold until the next start. A start pulse received while a search is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle start request |
| lvl_en_i | input | 1 | 1 = leveling search, 0 = fixed delay |
| start_pos_i | input | 3 | Initial strobe position, eighths of a clock |
| fixed_dly_i | input | 4 | Fixed write-data delay, eighths of a clock |
| clk_adj_i | input | 3 | Clock adjust, eighths of a clock, for the window check |
| hi_pre_req_i | input | 1 | A high-first write preamble is required |
| settle_i | input | 8 | Wait cycles after each strobe pulse, minus one |
| max_step_i | input | 7 | Largest step count above the start position |
| fb_i | input | 1 | DRAM feedback: clock level sampled on the strobe |
| dly_o | output | 8 | Current or final strobe position, eighths of a clock |
| dqs_pulse_o | output | 1 | Strobe pulse request |
| done_o | output | 1 | Search or fixed-delay result ready |
| err_o | output | 1 | Step limit reached without a low-to-high change |
| cfg_bad_o | output | 1 | Fixed-delay configuration outside rules |

## Verification
The hardest case to reach from the ports is a feedback level that is high at the start position, falls low a few steps later, and only then rises again, while short glitches try to break up the runs of three samples. Each such path must end with the same result as a clean lane. The bench drives the feedback from a lane model that is a function of the current `dly_o`. That model has a programmable high band below the true transition and an optional glitch that flips every fourth cycle. This makes the first-high path, a glitch-broken run of samples and the step-limit error each come about on purpose. A behavioural model compares every output on every cycle.

// File: rtl/wl_pkg.sv
package wl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PULSE  = 3'd1,
    ST_WAIT   = 3'd2,
    ST_SAMPLE = 3'd3,
    ST_DONE   = 3'd4
  } wl_state_e;
endpackage

// File: rtl/wl_rst_sync.sv
module wl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/wl_level_filter.sv
// Accepts a feedback level once RUN_N identical samples arrive back to back.
module wl_level_filter #(
  parameter int RUN_N = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en_i,
  input  logic smp_i,
  output logic acc_vld_o,
  output logic acc_lvl_o
);
  localparam int RUN_W = $clog2(RUN_N + 1);

  logic             last_q, last_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             match;

  assign match     = (run_q != '0) && (smp_i == last_q);
  assign acc_vld_o = smp_en_i && match && (run_q == RUN_W'(RUN_N - 1));
  assign acc_lvl_o = smp_i;

  always_comb begin
    last_d = last_q;
    run_d  = run_q;
    if (!smp_en_i) begin
      run_d = '0;
    end else if (match) begin
      if (run_q != RUN_W'(RUN_N)) run_d = run_q + RUN_W'(1);
    end else begin
      last_d = smp_i;
      run_d  = RUN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      run_q  <= '0;
    end else begin
      last_q <= last_d;
      run_q  <= run_d;
    end
  end
endmodule

// File: rtl/wl_cfg_check.sv
// Fixed-delay mode rule check: strobe window and low-preamble settings.
module wl_cfg_check #(
  parameter int FIX_W  = 4,
  parameter int ADJ_W  = 3,
  parameter int WIN_LO = 6,
  parameter int WIN_HI = 10,
  parameter int LOWPRE_A = 0,
  parameter int LOWPRE_B = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_en_i,
  input  logic             hi_pre_req_i,
  input  logic [FIX_W-1:0] fixed_dly_i,
  input  logic [ADJ_W-1:0] clk_adj_i,
  output logic             cfg_bad_o
);
  localparam int SUM_W = ((FIX_W > ADJ_W) ? FIX_W : ADJ_W) + 1;

  logic [SUM_W-1:0] edge_pos;
  logic             win_bad, pre_bad, bad_d, bad_q;

  assign edge_pos = SUM_W'(fixed_dly_i) + SUM_W'(clk_adj_i);
  assign win_bad  = (edge_pos < SUM_W'(WIN_LO)) || (edge_pos > SUM_W'(WIN_HI));
  assign pre_bad  = hi_pre_req_i &&
                    ((fixed_dly_i == FIX_W'(LOWPRE_A)) || (fixed_dly_i == FIX_W'(LOWPRE_B)));
  assign bad_d    = !lvl_en_i && (win_bad || pre_bad);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bad_q <= 1'b0;
    else        bad_q <= bad_d;
  end

  assign cfg_bad_o = bad_q;
endmodule

// File: rtl/wl_search_fsm.sv
module wl_search_fsm
  import wl_pkg::*;
#(
  parameter int POS_W  = 3,
  parameter int FIX_W  = 4,
  parameter int SET_W  = 8,
  parameter int STEP_W = 7,
  localparam int DLY_W = STEP_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              lvl_en_i,
  input  logic [POS_W-1:0]  start_pos_i,
  input  logic [FIX_W-1:0]  fixed_dly_i,
  input  logic [SET_W-1:0]  settle_i,
  input  logic [STEP_W-1:0] max_step_i,
  input  logic              acc_vld_i,
  input  logic              acc_lvl_i,
  output logic              smp_en_o,
  output logic              dqs_pulse_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DLY_W-1:0]  dly_o
);
  wl_state_e         state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d, max_q, max_d;
  logic [SET_W-1:0]  cnt_q, cnt_d, settle_q, settle_d;
  logic [POS_W-1:0]  base_q, base_d;
  logic [DLY_W-1:0]  dly_q, dly_d;
  logic              low_seen_q, low_seen_d;
  logic              err_q, err_d;

  always_comb begin
    state_d    = state_q;
    step_d     = step_q;
    max_d      = max_q;
    cnt_d      = cnt_q;
    settle_d   = settle_q;
    base_d     = base_q;
    dly_d      = dly_q;
    low_seen_d = low_seen_q;
    err_d      = err_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          err_d = 1'b0;
          if (!lvl_en_i) begin
            dly_d   = DLY_W'(fixed_dly_i);
            state_d = ST_DONE;
          end else begin
            base_d     = start_pos_i;
            max_d      = max_step_i;
            settle_d   = settle_i;
            step_d     = '0;
            low_seen_d = 1'b0;
            dly_d      = DLY_W'(start_pos_i);
            state_d    = ST_PULSE;
          end
        end
      end
      ST_PULSE: begin
        cnt_d   = settle_q;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (cnt_q == '0) state_d = ST_SAMPLE;
        else             cnt_d   = cnt_q - SET_W'(1);
      end
      ST_SAMPLE: begin
        if (acc_vld_i) begin
          if (low_seen_q && acc_lvl_i) begin
            state_d = ST_DONE;
          end else begin
            if (!acc_lvl_i) low_seen_d = 1'b1;
            if (step_q == max_q) begin
              err_d   = 1'b1;
              state_d = ST_DONE;
            end else begin
              step_d  = step_q + STEP_W'(1);
              dly_d   = DLY_W'(base_q) + DLY_W'(step_q) + DLY_W'(1);
              state_d = ST_PULSE;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      step_q     <= '0;
      max_q      <= '0;
      cnt_q      <= '0;
      settle_q   <= '0;
      base_q     <= '0;
      dly_q      <= '0;
      low_seen_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      step_q     <= step_d;
      max_q      <= max_d;
      cnt_q      <= cnt_d;
      settle_q   <= settle_d;
      base_q     <= base_d;
      dly_q      <= dly_d;
      low_seen_q <= low_seen_d;
      err_q      <= err_d;
    end
  end

  assign smp_en_o    = (state_q == ST_SAMPLE);
  assign dqs_pulse_o = (state_q == ST_PULSE);
  assign done_o      = (state_q == ST_DONE);
  assign err_o       = err_q;
  assign dly_o       = dly_q;
endmodule

// File: rtl/wl_delay_search.sv
module wl_delay_search #(
  parameter int POS_W  = 3,
  parameter int FIX_W  = 4,
  parameter int ADJ_W  = 3,
  parameter int SET_W  = 8,
  parameter int STEP_W = 7,
  parameter int RUN_N  = 3,
  localparam int DLY_W = STEP_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              lvl_en_i,
  input  logic [POS_W-1:0]  start_pos_i,
  input  logic [FIX_W-1:0]  fixed_dly_i,
  input  logic [ADJ_W-1:0]  clk_adj_i,
  input  logic              hi_pre_req_i,
  input  logic [SET_W-1:0]  settle_i,
  input  logic [STEP_W-1:0] max_step_i,
  input  logic              fb_i,
  output logic [DLY_W-1:0]  dly_o,
  output logic              dqs_pulse_o,
  output logic              done_o,
  output logic              err_o,
  output logic              cfg_bad_o
);
  logic rst_sync_n, smp_en, acc_vld, acc_lvl;

  wl_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  wl_level_filter #(.RUN_N(RUN_N)) u_filter (
    .clk(clk), .rst_n(rst_sync_n), .smp_en_i(smp_en), .smp_i(fb_i),
    .acc_vld_o(acc_vld), .acc_lvl_o(acc_lvl)
  );

  wl_search_fsm #(
    .POS_W(POS_W), .FIX_W(FIX_W), .SET_W(SET_W), .STEP_W(STEP_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .start_i(start_i), .lvl_en_i(lvl_en_i),
    .start_pos_i(start_pos_i), .fixed_dly_i(fixed_dly_i), .settle_i(settle_i),
    .max_step_i(max_step_i), .acc_vld_i(acc_vld), .acc_lvl_i(acc_lvl),
    .smp_en_o(smp_en), .dqs_pulse_o(dqs_pulse_o), .done_o(done_o),
    .err_o(err_o), .dly_o(dly_o)
  );

  wl_cfg_check #(.FIX_W(FIX_W), .ADJ_W(ADJ_W)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .lvl_en_i(lvl_en_i), .hi_pre_req_i(hi_pre_req_i),
    .fixed_dly_i(fixed_dly_i), .clk_adj_i(clk_adj_i), .cfg_bad_o(cfg_bad_o)
  );
endmodule

// File: rtl/wl_delay_search_chk.sv
module wl_delay_search_chk #(
  parameter int DLY_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             lvl_en_i,
  input logic [DLY_W-1:0] dly_o,
  input logic             dqs_pulse_o,
  input logic             done_o,
  input logic             err_o,
  input logic             cfg_bad_o
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_pulse_o |=> !dqs_pulse_o); // R3
  AST_DONE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !dqs_pulse_o); // R6
  AST_ERR_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o); // R7
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(dly_o) && $stable(err_o))); // R11
  AST_BYPASS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_i && !lvl_en_i) |=> (done_o && !err_o)); // R2
  AST_LVL_CFG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_en_i |=> !cfg_bad_o); // R10
endmodule

bind wl_delay_search wl_delay_search_chk #(.DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .lvl_en_i(lvl_en_i),
  .dly_o(dly_o), .dqs_pulse_o(dqs_pulse_o), .done_o(done_o),
  .err_o(err_o), .cfg_bad_o(cfg_bad_o)
);

// File: tb/wl_delay_search_bench.sv
`timescale 1ns/1ps
module wl_delay_search_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       lvl_en_i = 1'b1;
  logic [2:0] start_pos_i = '0;
  logic [3:0] fixed_dly_i = 4'd8;
  logic [2:0] clk_adj_i = '0;
  logic       hi_pre_req_i = 1'b0;
  logic [7:0] settle_i = 8'd1;
  logic [6:0] max_step_i = 7'd40;
  logic       fb_i;
  logic [7:0] dly_o;
  logic       dqs_pulse_o, done_o, err_o, cfg_bad_o;

  int  n_chk = 0;
  int  n_fail = 0;
  int  cyc = 0;
  int  hi_until = 0;
  int  thr = 5;
  bit  glitch_on = 0;
  logic glitch = 1'b0;
  int  pulses = 0;

  always #2 clk = ~clk;

  wl_delay_search u_wl_delay_search (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .lvl_en_i(lvl_en_i),
    .start_pos_i(start_pos_i), .fixed_dly_i(fixed_dly_i), .clk_adj_i(clk_adj_i),
    .hi_pre_req_i(hi_pre_req_i), .settle_i(settle_i), .max_step_i(max_step_i),
    .fb_i(fb_i), .dly_o(dly_o), .dqs_pulse_o(dqs_pulse_o), .done_o(done_o),
    .err_o(err_o), .cfg_bad_o(cfg_bad_o)
  );

  // Lane model: feedback is a function of the strobe position
  always_comb fb_i = ((int'(dly_o) < hi_until) || (int'(dly_o) >= thr)) ^ glitch;

  // Behavioural reference model
  int m_ph = 0;      // 0 idle 1 pulse 2 wait 3 sample 4 done
  int m_dly = 0, m_base = 0, m_step = 0, m_max = 0, m_settle = 0, m_cnt = 0, m_run = 0;
  bit m_err = 0, m_cfg = 0, m_low = 0, m_last = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_dly = 0; m_err = 0; m_cfg = 0; m_run = 0;
    end else begin
      m_cfg = !lvl_en_i &&
              ((int'(fixed_dly_i) + int'(clk_adj_i) < 6) || (int'(fixed_dly_i) + int'(clk_adj_i) > 10) ||
               (hi_pre_req_i && (fixed_dly_i == 4'd0 || fixed_dly_i == 4'd2)));
      case (m_ph)
        0, 4: if (start_i) begin
          m_err = 0;
          if (!lvl_en_i) begin m_dly = int'(fixed_dly_i); m_ph = 4; end
          else begin
            m_base = int'(start_pos_i); m_max = int'(max_step_i); m_settle = int'(settle_i);
            m_step = 0; m_low = 0; m_dly = m_base; m_ph = 1;
          end
        end
        1: begin m_cnt = m_settle; m_ph = 2; end
        2: if (m_cnt == 0) begin m_ph = 3; m_run = 0; end else m_cnt--;
        3: begin
          if (m_run > 0 && fb_i == m_last) m_run++;
          else begin m_last = fb_i; m_run = 1; end
          if (m_run == 3) begin
            if (m_low && m_last) m_ph = 4;
            else begin
              if (!m_last) m_low = 1;
              if (m_step == m_max) begin m_err = 1; m_ph = 4; end
              else begin m_step++; m_dly = m_base + m_step; m_ph = 1; end
            end
          end
        end
        default: m_ph = 0;
      endcase
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // Cycle-by-cycle compare away from the active edge
  always @(negedge clk) begin
    cyc++;
    glitch <= glitch_on && (cyc % 4 == 0);
    if (dqs_pulse_o) pulses++;
    chk("R3", "dqs_pulse_o", int'(dqs_pulse_o), int'(m_ph == 1));
    chk("R6", "done_o", int'(done_o), int'(m_ph == 4));
    chk("R7", "err_o", int'(err_o), int'(m_err));
    chk("R6", "dly_o", int'(dly_o), m_dly);
    chk("R8", "cfg_bad_o", int'(cfg_bad_o), int'(m_cfg));
  end

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000; i++) begin
      if (done_o) return;
      @(negedge clk);
    end
  endtask

  task automatic level(input int sp, input int hu, input int th, input int st, input int mx);
    start_pos_i = 3'(sp); hi_until = hu; thr = th; settle_i = 8'(st); max_step_i = 7'(mx);
    lvl_en_i = 1'b1;
    pulses = 0;
    pulse_start();
    wait_done();
    @(negedge clk);
  endtask

  task automatic cfg_case(input int fx, input int adj, input bit hp, input int exp, input string req);
    lvl_en_i = 1'b0; fixed_dly_i = 4'(fx); clk_adj_i = 3'(adj); hi_pre_req_i = hp;
    @(negedge clk); @(negedge clk);
    chk(req, "cfg_bad_o", int'(cfg_bad_o), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset done_o", int'(done_o), 0);
    chk("R1", "reset dly_o", int'(dly_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "idle done_o", int'(done_o), 0);
    chk("R1", "idle dqs_pulse_o", int'(dqs_pulse_o), 0);

    // R2 fixed-delay mode
    lvl_en_i = 1'b0; fixed_dly_i = 4'd8;
    pulse_start();
    chk("R2", "bypass done_o", int'(done_o), 1);
    chk("R2", "bypass dly_o", int'(dly_o), 8);
    chk("R2", "bypass err_o", int'(err_o), 0);

    // R8 window, R9 preamble
    cfg_case(3, 2, 0, 1, "R8");
    cfg_case(9, 2, 0, 1, "R8");
    cfg_case(4, 2, 0, 0, "R8");
    cfg_case(8, 2, 0, 0, "R8");
    cfg_case(2, 4, 1, 1, "R9");
    cfg_case(2, 4, 0, 0, "R9");
    cfg_case(0, 6, 1, 1, "R9");
    hi_pre_req_i = 1'b0;

    // R5/R6 clean search from 2 to 7
    level(2, 0, 7, 2, 20);
    chk("R6", "clean result", int'(dly_o), 7);
    chk("R6", "clean err", int'(err_o), 0);
    chk("R3", "pulse count", pulses, 6);

    // R5 first sample high: high band below 4, transition at 9
    level(1, 4, 9, 1, 20);
    chk("R5", "first-high result", int'(dly_o), 9);
    chk("R5", "first-high err", int'(err_o), 0);

    // R4 glitches every fourth cycle do not move the result
    glitch_on = 1;
    level(2, 0, 7, 0, 20);
    chk("R4", "glitch result", int'(dly_o), 7);
    level(1, 4, 9, 3, 20);
    chk("R4", "glitch first-high result", int'(dly_o), 9);
    glitch_on = 0;

    // R7 step limit
    level(0, 0, 100, 1, 5);
    chk("R7", "limit err", int'(err_o), 1);
    chk("R7", "limit dly", int'(dly_o), 5);

    // R10 fixed delay ignored with leveling on
    fixed_dly_i = 4'd0; hi_pre_req_i = 1'b1; clk_adj_i = 3'd0;
    level(3, 0, 6, 1, 20);
    chk("R10", "result with bad fixed", int'(dly_o), 6);
    chk("R10", "cfg_bad with leveling", int'(cfg_bad_o), 0);
    hi_pre_req_i = 1'b0;

    // R11 start during search ignored
    start_pos_i = 3'd0; hi_until = 0; thr = 6; settle_i = 8'd2; max_step_i = 7'd20;
    pulse_start();
    repeat (10) @(negedge clk);
    lvl_en_i = 1'b0; fixed_dly_i = 4'd3;
    start_i = 1'b1; @(negedge clk); start_i = 1'b0; lvl_en_i = 1'b1;
    wait_done();
    @(negedge clk);
    chk("R11", "busy start ignored", int'(dly_o), 6);
    repeat (5) @(negedge clk);
    chk("R11", "result held", int'(dly_o), 6);
    chk("R11", "done held", int'(done_o), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule